// File: doc/BRIEF.md
# Parallel LCD Write Sequencer (6800-style bus)

This block turns a single-cycle host write request into a complete write cycle on an asynchronous 6800-style parallel LCD bus. The request carries a register-select bit (command or data), an 8-bit value and a choice of one of two enable strobes. The block runs a fixed sequence of phases: address setup, enable strobe, data hold, and a recovery gap. Each phase has its own programmable length, counted in cycles of the internal clock.

All bus outputs come straight from flip-flops, so they change only on internal clock edges. The outputs are register select, a read/write line held low for a write, two enable strobes, and an 8-bit data value with a separate output-enable for the pad tri-state. A busy flag covers the whole access, including the recovery gap. A one-cycle done pulse marks the first idle cycle after it. Phase lengths are captured when a request is accepted, so software may reprogram them at any time without disturbing the access in flight.

Top module: `lcd_wr_seq`

## Requirements
- R1: While reset is asserted, busy, done, both enables and the data output-enable are 0, and the read/write line is 1.
- R2: A request is accepted on a clock edge where req_valid is 1 and busy is 0. busy is 1 from the next cycle onward. Requests presented while busy is 1 are ignored and do not change the captured register select or data.
- R3: The setup phase lasts cfg_setup cycles (0 to 31), with a value of 0 giving no setup. The selected enable rises exactly cfg_setup cycles after the first busy cycle.
- R4: The strobe phase lasts cfg_strobe cycles (1 to 63), and a programmed 0 is treated as 1. The selected enable is high for exactly that many cycles.
- R5: The hold phase lasts cfg_hold cycles (1 to 15), and a programmed 0 is treated as 1. The data output-enable stays 1 for that many cycles after the enable falls, then goes to 0.
- R6: After the hold phase, busy stays 1 for cfg_gap further cycles (0 to 3) with the data bus released.
- R7: req_sel = 0 selects lcd_e0 and req_sel = 1 selects lcd_e1. Only the selected enable pulses, and the two are never high together.
- R8: lcd_rs equals the accepted req_rs from the first busy cycle and is stable while busy. lcd_rw_n is 0 exactly while the data output-enable is 1, and any enable high implies both.
- R9: While lcd_d_oe is 1, lcd_d_o equals the accepted req_data. lcd_d_oe is 1 from the first busy cycle through the end of hold.
- R10: done is 1 for exactly one cycle: the first cycle in which busy is 0 after an access.
- R11: Changing the cfg_* inputs after acceptance has no effect on the access in progress. The total busy time is setup + strobe + hold + gap, using the values present at acceptance.
- R12: A new request presented during the done cycle is accepted, giving back-to-back accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sequencing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request strobe |
| req_rs | input | 1 | Register select for the write (0 command, 1 data) |
| req_sel | input | 1 | Enable choice: 0 drives lcd_e0, 1 drives lcd_e1 |
| req_data | input | DATA_W | Value to write |
| cfg_setup | input | SU_W | Setup phase length in cycles |
| cfg_strobe | input | STB_W | Strobe phase length in cycles (0 treated as 1) |
| cfg_hold | input | HLD_W | Hold phase length in cycles (0 treated as 1) |
| cfg_gap | input | GAP_W | Recovery gap in cycles |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| lcd_rs | output | 1 | Register select to the panel |
| lcd_rw_n | output | 1 | Read/write line, 0 during a write |
| lcd_e0 | output | 1 | Enable strobe 0 |
| lcd_e1 | output | 1 | Enable strobe 1 |
| lcd_d_o | output | DATA_W | Data bus value |
| lcd_d_oe | output | 1 | Data bus drive enable (0 = high impedance) |

## Verification
A corrupted phase counter or a wrong phase transition moves the enable edge, the fall of the data output-enable, or the fall of busy by at least one cycle. The bench compares every bus output against an arithmetic schedule on every cycle of every access, so such a fault is reported in the cycle where the first edge goes wrong. A capture fault shows on lcd_d_o or lcd_rs during the first busy cycle, because the bench presents different junk data while the block is busy. The bench sweeps all gap values, the end values of the setup, strobe and hold ranges, and both enables.

// File: rtl/lcd_wr_pkg.sv
package lcd_wr_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_SETUP  = 3'd1,
      PH_STROBE = 3'd2,
      PH_HOLD   = 3'd3,
      PH_GAP    = 3'd4
   } lcd_phase_e;

   // Phase that carries the bus (address/data valid, write asserted)
   function automatic logic phase_drives_bus(input lcd_phase_e ph);
      return (ph == PH_SETUP) || (ph == PH_STROBE) || (ph == PH_HOLD);
   endfunction

endpackage

// File: rtl/lcd_wr_cfg_hold.sv
module lcd_wr_cfg_hold #(
   parameter int SU_W  = 5,
   parameter int STB_W = 6,
   parameter int HLD_W = 4,
   parameter int GAP_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept_i,
   input  logic [SU_W-1:0]  su_i,
   input  logic [STB_W-1:0] stb_i,
   input  logic [HLD_W-1:0] hld_i,
   input  logic [GAP_W-1:0] gap_i,
   output logic [SU_W-1:0]  su_o,
   output logic [STB_W-1:0] stb_o,
   output logic [HLD_W-1:0] hld_o,
   output logic [GAP_W-1:0] gap_o
);

   logic [SU_W-1:0]  su_q;
   logic [STB_W-1:0] stb_q, stb_clamp;
   logic [HLD_W-1:0] hld_q, hld_clamp;
   logic [GAP_W-1:0] gap_q;

   // Strobe and hold have a one-cycle floor
   assign stb_clamp = (stb_i == '0) ? STB_W'(1) : stb_i;
   assign hld_clamp = (hld_i == '0) ? HLD_W'(1) : hld_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         su_q  <= '0;
         stb_q <= STB_W'(1);
         hld_q <= HLD_W'(1);
         gap_q <= '0;
      end else if (accept_i) begin
         su_q  <= su_i;
         stb_q <= stb_clamp;
         hld_q <= hld_clamp;
         gap_q <= gap_i;
      end
   end

   // On the accept cycle the live values are used; afterwards the snapshot
   assign su_o  = accept_i ? su_i      : su_q;
   assign stb_o = accept_i ? stb_clamp : stb_q;
   assign hld_o = accept_i ? hld_clamp : hld_q;
   assign gap_o = accept_i ? gap_i     : gap_q;

   assert property (@(posedge clk) disable iff (!rst_n)
      !accept_i |=> (stb_q != '0) && (hld_q != '0))
      else $error("assert_len_floor_R4: captured strobe/hold length is zero");

endmodule

// File: rtl/lcd_wr_phase_fsm.sv
module lcd_wr_phase_fsm
   import lcd_wr_pkg::*;
#(
   parameter int SU_W  = 5,
   parameter int STB_W = 6,
   parameter int HLD_W = 4,
   parameter int GAP_W = 2,
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid_i,
   input  logic [SU_W-1:0]  su_i,
   input  logic [STB_W-1:0] stb_i,
   input  logic [HLD_W-1:0] hld_i,
   input  logic [GAP_W-1:0] gap_i,
   output logic             accept_o,
   output lcd_phase_e       phase_nxt_o,
   output logic             busy_o,
   output logic             done_o
);

   lcd_phase_e       phase_q, phase_d;
   logic [CNT_W-1:0] cnt_q, cnt_d, len_d;
   logic             load_d, done_d, busy_q, done_q;

   assign accept_o = req_valid_i && !busy_q;

   // Phase sequencing, skipping empty setup and gap phases
   always_comb begin
      phase_d = phase_q;
      load_d  = 1'b0;
      done_d  = 1'b0;
      unique case (phase_q)
         PH_IDLE: begin
            if (accept_o) begin
               phase_d = (su_i != '0) ? PH_SETUP : PH_STROBE;
               load_d  = 1'b1;
            end
         end
         default: begin
            if (cnt_q == '0) begin
               unique case (phase_q)
                  PH_SETUP:  phase_d = PH_STROBE;
                  PH_STROBE: phase_d = PH_HOLD;
                  PH_HOLD:   phase_d = (gap_i != '0) ? PH_GAP : PH_IDLE;
                  default:   phase_d = PH_IDLE;
               endcase
               load_d = (phase_d != PH_IDLE);
               done_d = (phase_d == PH_IDLE);
            end
         end
      endcase
   end

   // Length of the phase being entered
   always_comb begin
      unique case (phase_d)
         PH_SETUP:  len_d = CNT_W'(su_i);
         PH_STROBE: len_d = CNT_W'(stb_i);
         PH_HOLD:   len_d = CNT_W'(hld_i);
         PH_GAP:    len_d = CNT_W'(gap_i);
         default:   len_d = CNT_W'(1);
      endcase
   end

   always_comb begin
      if (load_d)                 cnt_d = len_d - CNT_W'(1);
      else if (phase_q != PH_IDLE) cnt_d = cnt_q - CNT_W'(1);
      else                         cnt_d = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
         busy_q  <= (phase_d != PH_IDLE);
         done_q  <= done_d;
      end
   end

   assign phase_nxt_o = phase_d;
   assign busy_o      = busy_q;
   assign done_o      = done_q;

   assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !busy_q && $past(busy_q))
      else $error("assert_done_after_busy_R10");

   assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q)
      else $error("assert_done_single_R10");

   assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_STROBE) && $past(phase_q) != PH_STROBE |-> busy_q)
      else $error("assert_strobe_in_busy_R4");

   assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_IDLE) |-> !busy_q)
      else $error("assert_idle_not_busy_R2");

endmodule

// File: rtl/lcd_wr_pin_drv.sv
module lcd_wr_pin_drv
   import lcd_wr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int NUM_EN = 2,
   parameter int SEL_W  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept_i,
   input  logic              busy_i,
   input  logic              rs_i,
   input  logic [SEL_W-1:0]  sel_i,
   input  logic [DATA_W-1:0] data_i,
   input  lcd_phase_e        phase_nxt_i,
   output logic              rs_o,
   output logic              rw_n_o,
   output logic [NUM_EN-1:0] en_o,
   output logic [DATA_W-1:0] d_o,
   output logic              d_oe_o
);

   logic              rs_q, rw_n_q, oe_q;
   logic [SEL_W-1:0]  sel_q, sel_eff;
   logic [DATA_W-1:0] data_q;
   logic [NUM_EN-1:0] en_q;

   assign sel_eff = accept_i ? sel_i : sel_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rs_q   <= 1'b0;
         sel_q  <= '0;
         data_q <= '0;
         oe_q   <= 1'b0;
         rw_n_q <= 1'b1;
      end else begin
         if (accept_i) begin
            rs_q   <= rs_i;
            sel_q  <= sel_i;
            data_q <= data_i;
         end
         oe_q   <= phase_drives_bus(phase_nxt_i);
         rw_n_q <= !phase_drives_bus(phase_nxt_i);
      end
   end

   for (genvar gi = 0; gi < NUM_EN; gi++) begin : g_en
      always_ff @(posedge clk) begin
         if (!rst_n) en_q[gi] <= 1'b0;
         else        en_q[gi] <= (phase_nxt_i == PH_STROBE) &&
                                 (sel_eff == SEL_W'(gi));
      end
   end

   assign rs_o   = rs_q;
   assign rw_n_o = rw_n_q;
   assign en_o   = en_q;
   assign d_o    = data_q;
   assign d_oe_o = oe_q;

   assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(en_q))
      else $error("assert_one_enable_R7");

   assert property (@(posedge clk) disable iff (!rst_n)
      (en_q != '0) |-> oe_q && !rw_n_q)
      else $error("assert_enable_in_write_R8");

   assert property (@(posedge clk) disable iff (!rst_n)
      busy_i && $past(busy_i) |-> $stable(rs_q) && $stable(data_q))
      else $error("assert_capture_stable_R2");

   assert property (@(posedge clk) disable iff (!rst_n)
      oe_q |-> busy_i)
      else $error("assert_bus_within_busy_R9");

endmodule

// File: rtl/lcd_wr_seq.sv
module lcd_wr_seq
   import lcd_wr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SU_W   = 5,
   parameter int STB_W  = 6,
   parameter int HLD_W  = 4,
   parameter int GAP_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_rs,
   input  logic              req_sel,
   input  logic [DATA_W-1:0] req_data,
   input  logic [SU_W-1:0]   cfg_setup,
   input  logic [STB_W-1:0]  cfg_strobe,
   input  logic [HLD_W-1:0]  cfg_hold,
   input  logic [GAP_W-1:0]  cfg_gap,
   output logic              busy,
   output logic              done,
   output logic              lcd_rs,
   output logic              lcd_rw_n,
   output logic              lcd_e0,
   output logic              lcd_e1,
   output logic [DATA_W-1:0] lcd_d_o,
   output logic              lcd_d_oe
);

   localparam int NUM_EN = 2;
   localparam int SEL_W  = 1;
   localparam int MAX_AB = (SU_W  > STB_W) ? SU_W  : STB_W;
   localparam int MAX_CD = (HLD_W > GAP_W) ? HLD_W : GAP_W;
   localparam int CNT_W  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;

   initial begin
      if (DATA_W < 1) $error("lcd_wr_seq: DATA_W must be at least 1");
      if (SU_W < 1 || STB_W < 1 || HLD_W < 1 || GAP_W < 1)
         $error("lcd_wr_seq: phase length widths must be at least 1");
   end

   logic              accept;
   lcd_phase_e        phase_nxt;
   logic [SU_W-1:0]   su_eff;
   logic [STB_W-1:0]  stb_eff;
   logic [HLD_W-1:0]  hld_eff;
   logic [GAP_W-1:0]  gap_eff;
   logic [NUM_EN-1:0] en_vec;

   lcd_wr_cfg_hold #(
      .SU_W(SU_W), .STB_W(STB_W), .HLD_W(HLD_W), .GAP_W(GAP_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .accept_i(accept),
      .su_i(cfg_setup), .stb_i(cfg_strobe), .hld_i(cfg_hold), .gap_i(cfg_gap),
      .su_o(su_eff), .stb_o(stb_eff), .hld_o(hld_eff), .gap_o(gap_eff)
   );

   lcd_wr_phase_fsm #(
      .SU_W(SU_W), .STB_W(STB_W), .HLD_W(HLD_W), .GAP_W(GAP_W), .CNT_W(CNT_W)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid),
      .su_i(su_eff), .stb_i(stb_eff), .hld_i(hld_eff), .gap_i(gap_eff),
      .accept_o(accept), .phase_nxt_o(phase_nxt),
      .busy_o(busy), .done_o(done)
   );

   lcd_wr_pin_drv #(
      .DATA_W(DATA_W), .NUM_EN(NUM_EN), .SEL_W(SEL_W)
   ) u_pins (
      .clk(clk), .rst_n(rst_n), .accept_i(accept), .busy_i(busy),
      .rs_i(req_rs), .sel_i(req_sel), .data_i(req_data),
      .phase_nxt_i(phase_nxt),
      .rs_o(lcd_rs), .rw_n_o(lcd_rw_n), .en_o(en_vec),
      .d_o(lcd_d_o), .d_oe_o(lcd_d_oe)
   );

   assign lcd_e0 = en_vec[0];
   assign lcd_e1 = en_vec[1];

   assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> lcd_d_oe && !lcd_rw_n)
      else $error("assert_bus_from_start_R9");

   assert property (@(posedge clk) disable iff (!rst_n)
      lcd_d_oe != lcd_rw_n)
      else $error("assert_rw_tracks_oe_R8");

endmodule

// File: tb/lcd_wr_seq_tb_top.sv
`timescale 1ns/1ps
module lcd_wr_seq_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0, req_rs = 1'b0, req_sel = 1'b0;
   logic [7:0] req_data = '0;
   logic [4:0] cfg_setup = '0;
   logic [5:0] cfg_strobe = '0;
   logic [3:0] cfg_hold = '0;
   logic [1:0] cfg_gap = '0;
   logic       busy, done, lcd_rs, lcd_rw_n, lcd_e0, lcd_e1, lcd_d_oe;
   logic [7:0] lcd_d_o;

   int tests = 0;
   int fails = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   lcd_wr_seq dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rs(req_rs),
      .req_sel(req_sel), .req_data(req_data), .cfg_setup(cfg_setup),
      .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold), .cfg_gap(cfg_gap),
      .busy(busy), .done(done), .lcd_rs(lcd_rs), .lcd_rw_n(lcd_rw_n),
      .lcd_e0(lcd_e0), .lcd_e1(lcd_e1), .lcd_d_o(lcd_d_o), .lcd_d_oe(lcd_d_oe)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         if (fails < 40)
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Vector {busy,done,e0,e1,oe,rw_n}
   function automatic logic [5:0] obs();
      return {busy, done, lcd_e0, lcd_e1, lcd_d_oe, lcd_rw_n};
   endfunction

   // Called at a negedge with the block idle
   task automatic run_access(input int su, input int stb, input int hd, input int gp,
                             input bit sel, input bit rs, input logic [7:0] dat);
      int stbe = (stb == 0) ? 1 : stb;
      int hde  = (hd == 0) ? 1 : hd;
      int total = su + stbe + hde + gp;
      int busy_cnt = 0;
      req_valid = 1'b1; req_rs = rs; req_sel = sel; req_data = dat;
      cfg_setup = 5'(su); cfg_strobe = 6'(stb); cfg_hold = 4'(hd); cfg_gap = 2'(gp);
      for (int c = 0; c <= total; c++) begin
         logic [5:0] exp;
         bit stb_ph, oe_ph;
         string tag;
         @(negedge clk);
         stb_ph = (c >= su) && (c < su + stbe);
         oe_ph  = (c < su + stbe + hde);
         if (c == total) exp = 6'b010001;
         else exp = {1'b1, 1'b0, stb_ph && !sel, stb_ph && sel, oe_ph, !oe_ph};
         if (c == total)                 tag = "R10 done/idle";
         else if (c < su)                tag = "R3 setup";
         else if (stb_ph)                tag = "R4/R7 strobe";
         else if (oe_ph)                 tag = "R5 hold";
         else                            tag = "R6 gap";
         check(obs() == exp, tag, int'(obs()), int'(exp));
         if (busy) busy_cnt++;
         if (c < total) begin
            check(lcd_rs == rs, "R8 rs held", int'(lcd_rs), int'(rs));
            if (oe_ph)
               check(lcd_d_o == dat, "R9 data", int'(lcd_d_o), int'(dat));
         end
         if (c == 0) begin
            // R11: reprogram lengths; R2: junk request while busy
            cfg_setup = ~cfg_setup; cfg_strobe = ~cfg_strobe;
            cfg_hold = ~cfg_hold;   cfg_gap = ~cfg_gap;
            req_rs = ~rs; req_sel = ~sel; req_data = ~dat;
         end
         if (c == total - 1) req_valid = 1'b0;
      end
      check(busy_cnt == total, "R11 busy length", busy_cnt, total);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++; tests++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : stim
      int su_l[5]  = '{0, 1, 2, 5, 31};
      int stb_l[5] = '{0, 1, 2, 7, 63};
      int hd_l[4]  = '{0, 1, 3, 15};
      int idx = 0;
      repeat (3) @(negedge clk);
      check(obs() == 6'b000001, "R1 reset state", int'(obs()), 6'b000001);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(obs() == 6'b000001, "R1 idle after reset", int'(obs()), 6'b000001);
      for (int a = 0; a < 5; a++)
         for (int b = 0; b < 5; b++)
            for (int h = 0; h < 4; h++)
               for (int g = 0; g < 4; g++)
                  for (int s = 0; s < 2; s++) begin
                     // back-to-back: next request driven in the done cycle (R12)
                     run_access(su_l[a], stb_l[b], hd_l[h], g, s[0], idx[0],
                                8'((su_l[a]*7 + stb_l[b]*3 + hd_l[h]*11 + g*5 + s) ^ 8'hA5));
                     idx++;
                  end
      @(negedge clk);
      check(obs() == 6'b000001, "R12 quiet after last access", int'(obs()), 6'b000001);
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule